// File: doc/BRIEF.md
# Carry-Skip Binary Adder

This block adds two unsigned operands and a carry-in and produces the sum word and a carry-out. The operand width is split into equal groups. Inside a group the carry ripples from one full-adder cell to the next. Each group also forms a skip condition: the AND of its per-bit propagate terms, where a bit propagates when exactly one of its two operand bits is set. When that condition holds, a multiplexer passes the group's carry-in straight to its carry-out. Otherwise the group's own rippled carry is used, because the group either killed or generated the carry.

The sum bits of each group are always computed from the rippled internal carries, starting from that group's real carry-in. Only the carry handed to the next group goes through the skip multiplexer. The add logic itself is combinational. The result is captured in an output register with a synchronous active-high reset, so each result appears one clock after its operands are presented. With the default parameters the adder is 16 bits wide and is built from four 4-bit groups.

Top module: `skip_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum` and `cout` are cleared to zero at that edge.
- R2: At each rising edge where `rst` is low, the 17-bit value `{cout, sum}` takes the arithmetic value `a + b + cin` of the inputs sampled at that edge. The result is visible one clock after the operands.
- R3: When every bit position has exactly one operand bit set (`a ^ b` all ones), `cout` equals `cin`. For example, a=0xFFFF, b=0x0000 gives sum 0xFFFF with cout 0 when cin=0, and sum 0x0000 with cout 1 when cin=1.
- R4: A bit position where both operand bits are 1 does not count as propagating. Such a position generates a carry. For example, a=0x000F, b=0x000F, cin=0 gives 0x001E, and when both most significant bits are set, `cout` is 1.
- R5: When both most significant operand bits are 0, the carry is killed and `cout` is 0 whatever the carry-in. For example, a=0x0000, b=0x0000, cin=1 gives sum 0x0001 with cout 0.
- R6: Carries cross group boundaries, including through groups that skip. For example, a=0x0FFF, b=0x0001 gives 0x1000, and a=0x00FF, b=0x0F00, cin=1 gives 0x1000.
- R7: A reset asserted while operands are applied wins over those operands. The output reads zero at the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1  | Clock, rising edge active |
| rst  | input  | 1  | Synchronous active-high reset |
| a    | input  | 16 | First operand |
| b    | input  | 16 | Second operand |
| cin  | input  | 1  | Carry-in to the least significant bit |
| sum  | output | 16 | Registered sum bits |
| cout | output | 1  | Registered carry-out of the most significant bit |

## Verification
A wrong skip decision in one group shows up as an error of exactly one unit at that group's boundary. The following groups and `cout` are then off by that carry. Such an error appears on the very next clock after the operands, because there is no state apart from the output register. For this reason the stimulus targets patterns that make each group propagate fully, generate with both bits set, or kill. Every cycle is compared against a behavioural sum, so a single wrong carry is reported in the cycle it occurs.

// File: rtl/skip_adder_pkg.sv
package skip_adder_pkg;

  // number of carry groups for a given total width and group size
  function automatic int unsigned group_count(input int unsigned width,
                                              input int unsigned gsize);
    return (width + gsize - 1) / gsize;
  endfunction

  // majority of three: carry of a full-adder cell
  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (y & z) | (x & z);
  endfunction

endpackage

// File: rtl/skip_fa_cell.sv
module skip_fa_cell
  import skip_adder_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);

  always_comb begin
    s  = x ^ y ^ ci;
    co = maj3(x, y, ci);
  end

endmodule

// File: rtl/skip_group.sv
module skip_group #(
  parameter int unsigned GSIZE = 4
) (
  input  logic [GSIZE-1:0] x,
  input  logic [GSIZE-1:0] y,
  input  logic             ci,
  output logic [GSIZE-1:0] s,
  output logic             co
);

  logic [GSIZE:0]   chain;
  logic [GSIZE-1:0] prop;
  logic             skip;

  assign chain[0] = ci;

  generate
    for (genvar k = 0; k < GSIZE; k++) begin : g_bit
      skip_fa_cell cell_i (
        .x (x[k]),
        .y (y[k]),
        .ci(chain[k]),
        .s (s[k]),
        .co(chain[k+1])
      );
      // exclusive propagate: a bit with both inputs set must not skip
      assign prop[k] = x[k] ^ y[k];
    end
  endgenerate

  assign skip = &prop;
  assign co   = skip ? ci : chain[GSIZE];

endmodule

// File: rtl/skip_adder.sv
module skip_adder
  import skip_adder_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned GSIZE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int unsigned NGROUP = group_count(WIDTH, GSIZE);

  logic [NGROUP:0]  gcarry;
  logic [WIDTH-1:0] sum_c;

  assign gcarry[0] = cin;

  generate
    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
      skip_group #(.GSIZE(GSIZE)) grp_i (
        .x (a[g*GSIZE +: GSIZE]),
        .y (b[g*GSIZE +: GSIZE]),
        .ci(gcarry[g]),
        .s (sum_c[g*GSIZE +: GSIZE]),
        .co(gcarry[g+1])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_c;
      cout <= gcarry[NGROUP];
    end
  end

endmodule

// File: rtl/skip_adder_chk.sv
module skip_adder_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (sum == '0 && cout == 1'b0));

  // R2
  result_value_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)}
                               + {{WIDTH{1'b0}}, $past(cin)})));

  // R3
  full_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && (&($past(a) ^ $past(b)))) |-> (cout == $past(cin)));

  // R4
  msb_generate_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(a[WIDTH-1]) && $past(b[WIDTH-1])) |-> cout);

  // R5
  msb_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(a[WIDTH-1]) && !$past(b[WIDTH-1])) |-> !cout);

endmodule

bind skip_adder skip_adder_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/skip_adder_test.sv
module skip_adder_test;

  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  skip_adder #(.WIDTH(W), .GSIZE(4)) uut (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  task automatic compare(input string req, input logic [W:0] exp);
    checks++;
    if ({cout, sum} !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, {cout, sum}, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge capture, check at next fall
  task automatic add_chk(input string req, input logic [W-1:0] xa,
                         input logic [W-1:0] xb, input logic xc);
    int unsigned ref_v;
    a = xa; b = xb; cin = xc;
    ref_v = int'(xa) + int'(xb) + int'(xc);
    @(posedge clk);
    @(negedge clk);
    compare(req, ref_v[W:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1", '0);
    rst = 1'b0;

    add_chk("R3", 16'hFFFF, 16'h0000, 1'b0);
    add_chk("R3", 16'hFFFF, 16'h0000, 1'b1);
    add_chk("R3", 16'hA5A5, 16'h5A5A, 1'b1);
    add_chk("R3", 16'h0F0F, 16'hF0F0, 1'b0);
    add_chk("R4", 16'h000F, 16'h000F, 1'b0);
    add_chk("R4", 16'h8000, 16'h8000, 1'b0);
    add_chk("R4", 16'hF0F0, 16'hFF0F, 1'b1);
    add_chk("R5", 16'h0000, 16'h0000, 1'b1);
    add_chk("R5", 16'h7FFF, 16'h0000, 1'b1);
    add_chk("R6", 16'h0FFF, 16'h0001, 1'b0);
    add_chk("R6", 16'h00FF, 16'h0F00, 1'b1);
    add_chk("R6", 16'hFFFF, 16'hFFFF, 1'b1);
    add_chk("R6", 16'h1234, 16'h0DCB, 1'b1);

    for (int i = 0; i < 400; i++) begin
      add_chk("R2", W'($urandom), W'($urandom), 1'($urandom));
    end

    // R7: reset applied together with operands that would give a nonzero result
    a = 16'hFFFF; b = 16'h0001; cin = 1'b1; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare("R7", '0);
    rst = 1'b0;
    add_chk("R2", 16'h4321, 16'h1111, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule